// File: doc/BRIEF.md
# Module Clock/Reset State Sequencer

This block moves a set of peripheral modules between three clock/reset states: off (clock stopped, reset held), held-in-reset (clock running, reset held) and running (clock running, reset released). Each module has its own clock-enable and reset output. Software uses a small register bus to stage a requested state for each module. The staged value does nothing until software issues a go command.

A go command accepted while the block is idle freezes every module's staged state. It then runs one fixed-length transition for every module whose staged state differs from its present state, and raises a busy flag that software polls. Inside the transition the clock change comes first and the reset change follows one cycle later. When the busy flag drops, each moved module's status field holds its new state. Software also polls these status fields.

Top module: `modctl_top`

## Requirements
- R1: After reset every module output is off (mod_clk_en low, mod_rst high), every status and control register reads 0, and the busy flag reads 0.
- R2: Control register of module i is at CTL_BASE+4*i, with the staged state in bits [1:0] and an auxiliary bit at bit 9. Status register of module i is at STAT_BASE+4*i, with the present state in bits [1:0]. The busy flag is bit 0 at BUSY_ADDR, and the go command is bit 0 at CMD_ADDR. Unused bits and unmapped addresses read 0. Read data appears on bus_rdata in the cycle after bus_rd.
- R3: Writing a control register changes no output and no status field. Outputs change only while busy is set.
- R4: State codes are 0 = off (clk_en 0, rst 1), 1 = held in reset (clk_en 1, rst 1) and 3 = running (clk_en 1, rst 0).
- R5: Writing 1 to bit 0 at CMD_ADDR while idle sets busy for exactly TRANS_CYC cycles when some module is pending. At the edge where busy clears, each pending module's status field equals its frozen staged state. A write to CMD_ADDR with bit 0 clear does nothing.
- R6: A pending module's clock enable takes its new value at the first edge after the go edge, and its reset at the second edge. Going to off therefore stops the clock before asserting reset. Going from off to running releases reset one cycle after the clock starts.
- R7: A go command written while busy is ignored, and busy still clears on schedule. Staged states written during busy do not affect the running transition and stay pending.
- R8: A go command with no pending module sets busy for one cycle only.
- R9: Control and status slots with index at or above NUM_MOD ignore writes and read 0.
- R10: The auxiliary bit is stored, read back and kept independent of the staged state, and has no effect on any output.
- R11: A control write carrying code 2 leaves the staged field unchanged when STRICT_CODE=1, and stores 0 when STRICT_CODE=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| mod_clk_en | output | NUM_MOD | Per-module clock enable |
| mod_rst | output | NUM_MOD | Per-module reset, active high |

## Verification
The bench builds the block with NUM_MOD=6 and SLOT_W=4. This leaves ten control and status slots unmapped, so the ignored-write and zero-readback cases can be reached. TRANS_CYC=4 leaves room for two idle cycles after the clock and reset phases, so the bench can count the busy length exactly and can land a go command inside a running transition. STRICT_CODE=1 puts the code-2 write under test.

// File: rtl/modctl_pkg.sv
package modctl_pkg;

   typedef enum logic [1:0] {
      ST_OFF  = 2'd0,
      ST_SRST = 2'd1,
      ST_RSVD = 2'd2,
      ST_ON   = 2'd3
   } mstate_t;

   localparam int AUX_BIT = 9;

   // Clock enable implied by a state code.
   function automatic logic st_clk(input logic [1:0] s);
      return s != ST_OFF;
   endfunction

   // Reset level implied by a state code.
   function automatic logic st_rst(input logic [1:0] s);
      return s != ST_ON;
   endfunction

endpackage

// File: rtl/modctl_regs.sv
module modctl_regs
   import modctl_pkg::*;
#(
   parameter int NUM_MOD = 6,
   parameter int SLOT_W = 4,
   parameter int ADDR_W = 12,
   parameter logic [ADDR_W-1:0] CTL_BASE  = 'h200,
   parameter logic [ADDR_W-1:0] STAT_BASE = 'h100,
   parameter logic [ADDR_W-1:0] CMD_ADDR  = 'h010,
   parameter logic [ADDR_W-1:0] BUSY_ADDR = 'h014,
   parameter bit STRICT_CODE = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_wr,
   input  logic                      bus_rd,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [31:0]               bus_wdata,
   input  logic                      busy,
   input  logic [NUM_MOD-1:0][1:0]   cur,
   output logic [NUM_MOD-1:0][1:0]   nxt,
   output logic                      go_req,
   output logic [31:0]               bus_rdata
);
   localparam int WIN_W = SLOT_W + 2;

   logic [SLOT_W-1:0]  slot;
   logic               ctl_hit, stat_hit;
   logic [NUM_MOD-1:0] aux_q;
   logic [1:0]         wr_code;
   logic               wr_keep;
   logic [31:0]        rd_next, rdata_q;
   logic               unused_wdata;

   assign unused_wdata = ^{bus_wdata[31:10], bus_wdata[8:2]};

   assign slot     = bus_addr[WIN_W-1:2];
   assign ctl_hit  = (bus_addr[ADDR_W-1:WIN_W] == CTL_BASE[ADDR_W-1:WIN_W]) &&
                     (bus_addr[1:0] == 2'b00);
   assign stat_hit = (bus_addr[ADDR_W-1:WIN_W] == STAT_BASE[ADDR_W-1:WIN_W]) &&
                     (bus_addr[1:0] == 2'b00);
   assign go_req   = bus_wr && (bus_addr == CMD_ADDR) && bus_wdata[0];

   // Variant: how the reserved code 2 is handled on a control write.
   if (STRICT_CODE) begin : g_code_strict
      assign wr_keep = (bus_wdata[1:0] == ST_RSVD);
      assign wr_code = bus_wdata[1:0];
   end else begin : g_code_loose
      assign wr_keep = 1'b0;
      assign wr_code = (bus_wdata[1:0] == ST_RSVD) ? ST_OFF : bus_wdata[1:0];
   end

   for (genvar i = 0; i < NUM_MOD; i++) begin : g_ctl
      logic hit_i;
      assign hit_i = bus_wr && ctl_hit && (slot == SLOT_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            nxt[i]   <= ST_OFF;
            aux_q[i] <= 1'b0;
         end else if (hit_i) begin
            aux_q[i] <= bus_wdata[AUX_BIT];
            if (!wr_keep) nxt[i] <= wr_code;
         end
      end
   end

   always_comb begin
      rd_next = '0;
      for (int k = 0; k < NUM_MOD; k++) begin
         if (ctl_hit && slot == SLOT_W'(k)) begin
            rd_next[1:0]    = nxt[k];
            rd_next[AUX_BIT] = aux_q[k];
         end
         if (stat_hit && slot == SLOT_W'(k)) rd_next[1:0] = cur[k];
      end
      if (bus_addr == BUSY_ADDR) rd_next[0] = busy;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_rd) rdata_q <= rd_next;
   end

   assign bus_rdata = rdata_q;

endmodule

// File: rtl/modctl_seq.sv
module modctl_seq #(
   parameter int TRANS_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_req,
   input  logic any_pend,
   output logic busy,
   output logic start,
   output logic ph_clk,
   output logic ph_rst,
   output logic finish
);
   localparam int CNT_W = $clog2(TRANS_CYC);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TRANS_CYC - 1);

   logic             busy_q, work_q;
   logic [CNT_W-1:0] cnt_q;

   assign busy   = busy_q;
   assign start  = go_req && !busy_q;
   assign ph_clk = busy_q && work_q && (cnt_q == '0);
   assign ph_rst = busy_q && work_q && (cnt_q == CNT_W'(1));
   assign finish = busy_q && (!work_q || cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         work_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         work_q <= any_pend;
         cnt_q  <= '0;
      end else if (finish) begin
         busy_q <= 1'b0;
         work_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q) begin
         cnt_q  <= cnt_q + CNT_W'(1);
      end
   end

endmodule

// File: rtl/modctl_lane.sv
module modctl_lane
   import modctl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       ph_clk,
   input  logic       ph_rst,
   input  logic       finish,
   input  logic [1:0] nxt,
   output logic       pend,
   output logic [1:0] cur,
   output logic       clk_en,
   output logic       mrst
);
   logic [1:0] tgt_q, cur_q;
   logic       act_q, clk_q, rst_q;

   assign pend   = (nxt != cur_q);
   assign cur    = cur_q;
   assign clk_en = clk_q;
   assign mrst   = rst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_q <= ST_OFF;
         cur_q <= ST_OFF;
         act_q <= 1'b0;
         clk_q <= 1'b0;
         rst_q <= 1'b1;
      end else begin
         if (start) begin
            tgt_q <= nxt;
            act_q <= pend;
         end
         if (ph_clk && act_q) clk_q <= st_clk(tgt_q);
         if (ph_rst && act_q) rst_q <= st_rst(tgt_q);
         if (finish && act_q) begin
            cur_q <= tgt_q;
            act_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/modctl_top.sv
module modctl_top
   import modctl_pkg::*;
#(
   parameter int NUM_MOD = 6,
   parameter int SLOT_W = 4,
   parameter int ADDR_W = 12,
   parameter int TRANS_CYC = 4,
   parameter logic [ADDR_W-1:0] CTL_BASE  = 'h200,
   parameter logic [ADDR_W-1:0] STAT_BASE = 'h100,
   parameter logic [ADDR_W-1:0] CMD_ADDR  = 'h010,
   parameter logic [ADDR_W-1:0] BUSY_ADDR = 'h014,
   parameter bit STRICT_CODE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic [NUM_MOD-1:0] mod_clk_en,
   output logic [NUM_MOD-1:0] mod_rst
);
   localparam int WIN_W = SLOT_W + 2;

   // Elaboration-time parameter checks.
   if (NUM_MOD < 1 || NUM_MOD > (1 << SLOT_W)) begin : g_bad_count
      $error("NUM_MOD must lie in 1 .. 2**SLOT_W");
   end
   if (TRANS_CYC < 3) begin : g_bad_len
      $error("TRANS_CYC must be at least 3");
   end
   if (ADDR_W <= WIN_W) begin : g_bad_addr
      $error("ADDR_W too small for the slot window");
   end
   if (CTL_BASE[WIN_W-1:0] != '0 || STAT_BASE[WIN_W-1:0] != '0) begin : g_bad_base
      $error("register windows must be aligned to their size");
   end

   logic [NUM_MOD-1:0][1:0] nxt_vec, cur_vec;
   logic [NUM_MOD-1:0]      pend_vec;
   logic go_req, busy, start, ph_clk, ph_rst, finish;

   modctl_regs #(
      .NUM_MOD(NUM_MOD), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W),
      .CTL_BASE(CTL_BASE), .STAT_BASE(STAT_BASE),
      .CMD_ADDR(CMD_ADDR), .BUSY_ADDR(BUSY_ADDR), .STRICT_CODE(STRICT_CODE)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy),
      .cur(cur_vec), .nxt(nxt_vec), .go_req(go_req), .bus_rdata(bus_rdata)
   );

   modctl_seq #(.TRANS_CYC(TRANS_CYC)) seq_i (
      .clk(clk), .rst_n(rst_n), .go_req(go_req), .any_pend(|pend_vec),
      .busy(busy), .start(start), .ph_clk(ph_clk), .ph_rst(ph_rst),
      .finish(finish)
   );

   for (genvar i = 0; i < NUM_MOD; i++) begin : g_lane
      modctl_lane lane_i (
         .clk(clk), .rst_n(rst_n), .start(start), .ph_clk(ph_clk),
         .ph_rst(ph_rst), .finish(finish), .nxt(nxt_vec[i]),
         .pend(pend_vec[i]), .cur(cur_vec[i]),
         .clk_en(mod_clk_en[i]), .mrst(mod_rst[i])
      );
   end

endmodule

// File: rtl/modctl_chk.sv
module modctl_chk #(
   parameter int NUM_MOD = 6,
   parameter int TRANS_CYC = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    busy,
   input logic [NUM_MOD-1:0][1:0] cur,
   input logic [NUM_MOD-1:0]      clk_en,
   input logic [NUM_MOD-1:0]      mrst
);
   localparam int CW = $clog2(TRANS_CYC + 2) + 1;
   localparam logic [CW-1:0] SAT = {CW{1'b1}};

   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_q <= '0;
      else if (busy)   run_q <= (run_q == SAT) ? run_q : run_q + CW'(1);
      else             run_q <= '0;
   end

   // R5: busy never lasts longer than TRANS_CYC cycles
   a_r5_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> run_q < CW'(TRANS_CYC));

   // R5: status fields move only where busy clears
   a_r5_status_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur) |-> $fell(busy));

   // R3: outputs hold while idle
   a_r3_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(busy) |-> ($stable(clk_en) && $stable(mrst)));

   for (genvar i = 0; i < NUM_MOD; i++) begin : g_bit
      // R6: a clock starts only while reset is held
      a_r6_reset_at_clk_start: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(clk_en[i]) |-> mrst[i]);
      // R6: reset releases only after a running clock
      a_r6_clk_before_release: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(mrst[i]) |-> $past(clk_en[i]));
      // R6: reset applied to a stopped module follows the clock stop
      a_r6_gate_before_reset: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(mrst[i]) && !clk_en[i]) |-> !$past(clk_en[i]));
   end

endmodule

bind modctl_top modctl_chk #(.NUM_MOD(NUM_MOD), .TRANS_CYC(TRANS_CYC)) chk_i (
   .clk(clk), .rst_n(rst_n), .busy(busy), .cur(cur_vec),
   .clk_en(mod_clk_en), .mrst(mod_rst)
);

// File: tb/modctl_top_tb_top.sv
module modctl_top_tb_top;
   localparam int NM = 6;
   localparam int SW = 4;
   localparam int TC = 4;
   localparam logic [11:0] CB   = 12'h200;
   localparam logic [11:0] SB   = 12'h100;
   localparam logic [11:0] CMDA = 12'h010;
   localparam logic [11:0] BSYA = 12'h014;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [NM-1:0] mod_clk_en, mod_rst;

   int n_chk = 0, n_err = 0;
   logic [1:0] nxt_m [16];
   logic [1:0] cur_m [16];
   logic       aux_m [16];

   always #5 clk = ~clk;

   modctl_top #(
      .NUM_MOD(NM), .SLOT_W(SW), .ADDR_W(12), .TRANS_CYC(TC),
      .CTL_BASE(CB), .STAT_BASE(SB), .CMD_ADDR(CMDA), .BUSY_ADDR(BSYA),
      .STRICT_CODE(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .mod_clk_en(mod_clk_en), .mod_rst(mod_rst)
   );

   function automatic logic exp_clk(input logic [1:0] s);
      return s != 2'd0;
   endfunction
   function automatic logic exp_rst(input logic [1:0] s);
      return s != 2'd3;
   endfunction
   function automatic logic [31:0] exp_ctl(input int i);
      if (i >= NM) return 32'h0;
      return {22'h0, aux_m[i], 7'h0, nxt_m[i]};
   endfunction
   function automatic logic [11:0] ctl_a(input int i);
      return CB + 12'(4 * i);
   endfunction
   function automatic logic [11:0] stat_a(input int i);
      return SB + 12'(4 * i);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic ctl_write(input int i, input logic [31:0] d);
      bus_write(ctl_a(i), d);
      if (i < NM) begin
         aux_m[i] = d[9];
         if (d[1:0] != 2'd2) nxt_m[i] = d[1:0];
      end
   endtask

   task automatic go_and_wait();
      bus_write(CMDA, 32'h1);
      repeat (TC) @(negedge clk);
      for (int i = 0; i < NM; i++) cur_m[i] = nxt_m[i];
   endtask

   task automatic check_all(input string req);
      logic [31:0] d;
      for (int i = 0; i < NM; i++) begin
         chk({req, " R4 clk_en"}, 32'(mod_clk_en[i]), 32'(exp_clk(cur_m[i])));
         chk({req, " R4 rst"}, 32'(mod_rst[i]), 32'(exp_rst(cur_m[i])));
         bus_read(stat_a(i), d);
         chk({req, " R5 status"}, d, {30'h0, cur_m[i]});
         bus_read(ctl_a(i), d);
         chk({req, " R2 ctl"}, d, exp_ctl(i));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'h1d5c_07a3));
      for (int i = 0; i < 16; i++) begin
         nxt_m[i] = 2'd0; cur_m[i] = 2'd0; aux_m[i] = 1'b0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 clk_en", 32'(mod_clk_en), 32'h0);
      chk("R1 rst", 32'(mod_rst), 32'((1 << NM) - 1));
      bus_read(BSYA, d);
      chk("R1 busy", d, 32'h0);
      check_all("R1");
      bus_read(12'h7fc, d);
      chk("R2 unmapped", d, 32'h0);

      // R3 + R6: off -> running on module 0
      ctl_write(0, 32'h3);
      repeat (2) @(negedge clk);
      chk("R3 staged clk", 32'(mod_clk_en[0]), 32'h0);
      bus_read(stat_a(0), d);
      chk("R3 staged status", d, 32'h0);
      bus_write(CMDA, 32'h1);
      chk("R6 clk not yet", 32'(mod_clk_en[0]), 32'h0);
      bus_read(BSYA, d);
      chk("R5 busy set", d, 32'h1);
      chk("R6 clk first", 32'(mod_clk_en[0]), 32'h1);
      chk("R6 rst held", 32'(mod_rst[0]), 32'h1);
      @(negedge clk);
      chk("R6 rst release", 32'(mod_rst[0]), 32'h0);
      repeat (TC - 2) @(negedge clk);
      cur_m[0] = 2'd3;
      check_all("R6 on");

      // R5: busy length
      ctl_write(2, 32'h1);
      bus_write(CMDA, 32'h1);
      for (int k = 1; k <= TC + 1; k++) begin
         bus_read(BSYA, d);
         chk("R5 busy length", d, (k <= TC) ? 32'h1 : 32'h0);
      end
      cur_m[2] = 2'd1;
      check_all("R5");

      // R6: running -> off on module 0
      ctl_write(0, 32'h0);
      bus_write(CMDA, 32'h1);
      chk("R6 off clk still on", 32'(mod_clk_en[0]), 32'h1);
      @(negedge clk);
      chk("R6 off clk gated", 32'(mod_clk_en[0]), 32'h0);
      chk("R6 off rst not yet", 32'(mod_rst[0]), 32'h0);
      @(negedge clk);
      chk("R6 off rst on", 32'(mod_rst[0]), 32'h1);
      repeat (TC - 2) @(negedge clk);
      cur_m[0] = 2'd0;

      // R8: empty go
      bus_write(CMDA, 32'h1);
      bus_read(BSYA, d);
      chk("R8 busy one cycle", d, 32'h1);
      bus_read(BSYA, d);
      chk("R8 busy cleared", d, 32'h0);

      // R5: go bit clear does nothing
      ctl_write(4, 32'h3);
      bus_write(CMDA, 32'h2);
      bus_read(BSYA, d);
      chk("R5 no go", d, 32'h0);
      chk("R5 no go clk", 32'(mod_clk_en[4]), 32'h0);
      go_and_wait();

      // R7: go while busy, staging during busy
      ctl_write(1, 32'h3);
      bus_write(CMDA, 32'h1);
      ctl_write(1, 32'h1);
      bus_write(CMDA, 32'h1);
      bus_read(BSYA, d);
      chk("R7 busy kept", d, 32'h1);
      bus_read(BSYA, d);
      chk("R7 busy kept", d, 32'h1);
      bus_read(BSYA, d);
      chk("R7 no restart", d, 32'h0);
      cur_m[1] = 2'd3;
      check_all("R7");
      go_and_wait();
      check_all("R7 second go");

      // R9: out-of-range slots
      bus_write(ctl_a(7), 32'h203);
      bus_read(ctl_a(7), d);
      chk("R9 ctl slot 7", d, 32'h0);
      bus_write(ctl_a(15), 32'h3);
      bus_read(ctl_a(15), d);
      chk("R9 ctl slot 15", d, 32'h0);
      bus_read(stat_a(8), d);
      chk("R9 stat slot 8", d, 32'h0);
      go_and_wait();
      check_all("R9");

      // R10: aux bit
      ctl_write(3, 32'hffff_fdfd);
      ctl_write(5, 32'h0000_0203);
      bus_read(ctl_a(5), d);
      chk("R10 aux readback", d, 32'h203);
      bus_read(ctl_a(3), d);
      chk("R10 aux clear", d, 32'h1);
      chk("R10 no output", 32'(mod_clk_en[5]), 32'h0);

      // R11: code 2 keeps field
      ctl_write(3, 32'h0000_0202);
      bus_read(ctl_a(3), d);
      chk("R11 code 2", d, 32'h201);
      go_and_wait();
      check_all("R10 R11");

      // Random mix
      for (int it = 0; it < 150; it++) begin
         int op, idx;
         op  = $urandom_range(0, 99);
         idx = $urandom_range(0, 15);
         if (op < 60) begin
            ctl_write(idx, $urandom());
         end else if (op < 85) begin
            go_and_wait();
            check_all("R5 random");
         end else begin
            bus_read(ctl_a(idx), d);
            chk("R9 random ctl", d, exp_ctl(idx));
         end
      end
      go_and_wait();
      check_all("R3 final");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule